// File: doc/BRIEF.md
# Signed Integer ALU with Split Overflow and Underflow Flags

This block is the integer execute unit of a small processor pipeline. On every cycle it takes two signed register operands, a short immediate and an opcode, and combinationally produces a result word and a halt signal. The result always wraps modulo 2^W in two's complement.

Alongside the result it keeps two sticky condition flags. The overflow flag records a true result above the largest positive value. The underflow flag records a true result below the most negative value. The two are never merged into one bit. The flags are written only on a clock edge where `valid` is high. Each class of opcode has its own rule: arithmetic loads both flags from its own outcome, division loads overflow and forces underflow low, bitwise logic clears both, and no-op or return leaves both untouched.

A zero divisor is treated as a halt request. The `halt` output rises in the same cycle, the result is forced to the largest positive value, and the overflow flag is set on the edge.

Top module: `int_alu_flags`

## Requirements
- R1: Opcode encoding on `opcode` is: 0 no-op, 1 add, 2 subtract, 3 multiply, 4 quotient, 5 remainder, 6 and, 7 or, 8 xor, 9 not, 10 add-immediate, 11 subtract-immediate, 12 and-immediate, 13 or-immediate, 14 xor-immediate, 15 return. The immediate forms use `imm` sign-extended from bit IMM_W-1 in place of `op_b`. Add and subtract results wrap modulo 2^W.
- R2: For add and add-immediate, with second operand b, the next overflow flag is 1 exactly when b >= 0 and a > MAX - b. The next underflow flag is 1 exactly when b < 0 and a < MIN - b.
- R3: For subtract and subtract-immediate, the next overflow flag is 1 exactly when b < 0 and a > MAX + b. The next underflow flag is 1 exactly when b >= 0 and a < MIN + b.
- R4: Multiply returns the low W bits of the signed product. The overflow flag is loaded with (true product > MAX) and the underflow flag with (true product < MIN).
- R5: Quotient truncates toward zero, and remainder takes the sign of the dividend. MIN divided by -1 sets overflow and returns MIN for quotient and 0 for remainder. Both division opcodes load underflow with 0.
- R6: A quotient or remainder with `op_b` = 0 drives `halt` high in that cycle and result MAX (0x7FFFFFFF at W=32). It sets the overflow flag on the edge.
- R7: The logic opcodes give a&b, a|b, a^b and ~a, with the immediate forms using the extended immediate. Each logic opcode clears both flags.
- R8: No-op and return give result 0 and leave both flags unchanged.
- R9: The flags change only on a rising clock edge where `valid` is 1. With `valid` low they hold, whatever the opcode and operands.
- R10: An active-low reset clears both flags.
- R11: The overflow and underflow flags are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Operation issued this cycle; commits the flags |
| opcode | input | 4 | Operation select (encoding in R1) |
| op_a | input | W | First signed operand |
| op_b | input | W | Second signed operand, used by register forms |
| imm | input | IMM_W | Signed immediate for the immediate forms |
| result | output | W | Combinational result |
| halt | output | 1 | Zero-divisor halt request, qualified by valid |
| of_flag | output | 1 | Registered overflow flag |
| uf_flag | output | 1 | Registered underflow flag |

## Verification
The bench drives operands near both ends of the range, so that add and subtract straddle MAX and MIN from each side. A design that swapped the two flags, or that set overflow on a negative excursion, would be caught there. Multiply is driven with mixed signs and with -1, and MIN times -1 must raise overflow and not underflow. Division is probed with a zero divisor, where a wrong design would return garbage or miss `halt`, and with MIN / -1, where a wrong design would trap or leave overflow low. Idle cycles that carry an overflowing add, and no-op or return operations issued after a flag is set, expose any design that lets the flags drift when they should hold.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_MUL  = 4'd3,
    OP_QUOT = 4'd4,
    OP_REM  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_NOT  = 4'd9,
    OP_ADDI = 4'd10,
    OP_SUBI = 4'd11,
    OP_ANDI = 4'd12,
    OP_ORI  = 4'd13,
    OP_XORI = 4'd14,
    OP_RET  = 4'd15
  } alu_op_e;

  // how an opcode treats the condition flags
  typedef enum logic [1:0] {
    FLG_KEEP  = 2'd0,
    FLG_LOAD  = 2'd1,
    FLG_CLEAR = 2'd2
  } flag_act_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         ovf,
  output logic         unf
);
  localparam int EW = W + 1;

  // one guard bit: top two bits 01 mean above MAX, 10 mean below MIN
  function automatic logic [EW-1:0] ext_op(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic sub);
    logic [EW-1:0] xe, ye;
    xe = {x[W-1], x};
    ye = {y[W-1], y};
    return sub ? (xe - ye) : (xe + ye);
  endfunction

  logic [EW-1:0] wide;

  always_comb begin
    wide = ext_op(a, b, do_sub);
    sum  = wide[W-1:0];
    ovf  = (wide[EW-1:EW-2] == 2'b01);
    unf  = (wide[EW-1:EW-2] == 2'b10);
  end
endmodule

// File: rtl/alu_mult.sv
module alu_mult #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod,
  output logic         ovf,
  output logic         unf
);
  localparam int PW = 2 * W;

  function automatic logic [PW-1:0] full_mul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic signed [PW-1:0] xs, ys;
    xs = PW'($signed(x));
    ys = PW'($signed(y));
    return xs * ys;
  endfunction

  logic [PW-1:0] full;
  logic [W:0]    upper;

  always_comb begin
    full  = full_mul(a, b);
    prod  = full[W-1:0];
    upper = full[PW-1:W-1];
    // a fitting product has its upper bits all equal to the sign
    ovf   = !full[PW-1] && (upper != '0);
    unf   =  full[PW-1] && (upper != '1);
  end
endmodule

// File: rtl/alu_divide.sv
module alu_divide #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         want_rem,
  output logic [W-1:0] res,
  output logic         ovf,
  output logic         zero_div
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  function automatic logic [W-1:0] trunc_div(input logic [W-1:0] x, input logic [W-1:0] y,
                                             input logic rem);
    logic signed [W-1:0] xs, ys;
    xs = $signed(x);
    ys = $signed(y);
    return rem ? W'(xs % ys) : W'(xs / ys);
  endfunction

  logic neg_wrap;

  always_comb begin
    zero_div = (b == '0);
    neg_wrap = (a == MINV) && (b == '1);
    ovf      = zero_div || neg_wrap;
    if (zero_div)      res = MAXV;
    else if (neg_wrap) res = want_rem ? '0 : MINV;
    else               res = trunc_div(a, b, want_rem);
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      commit,
  input  flag_act_e act,
  input  logic      of_in,
  input  logic      uf_in,
  output logic      of_q,
  output logic      uf_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      of_q <= 1'b0;
      uf_q <= 1'b0;
    end else if (commit) begin
      unique case (act)
        FLG_LOAD: begin
          of_q <= of_in;
          uf_q <= uf_in;
        end
        FLG_CLEAR: begin
          of_q <= 1'b0;
          uf_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
  import alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [3:0]       opcode,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic [IMM_W-1:0] imm,
  output logic [W-1:0]     result,
  output logic             halt,
  output logic             of_flag,
  output logic             uf_flag
);
  localparam int PADW = W - IMM_W;

  alu_op_e      op;
  logic [W-1:0] imm_ext;
  logic [W-1:0] b_sel;
  logic         use_imm;
  logic         is_sub;
  logic         is_rem;

  logic [W-1:0] as_sum, mul_prod, div_res;
  logic         as_ovf, as_unf, mul_ovf, mul_unf, div_ovf, div_zero;

  // named events for the checker
  flag_act_e    flag_act;
  logic         nxt_of, nxt_uf;
  logic         flag_commit;

  generate
    if (PADW > 0) begin : g_sext
      assign imm_ext = {{PADW{imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign imm_ext = imm[W-1:0];
    end
  endgenerate

  always_comb begin
    op      = alu_op_e'(opcode);
    use_imm = (op == OP_ADDI) || (op == OP_SUBI) || (op == OP_ANDI) ||
              (op == OP_ORI)  || (op == OP_XORI);
    is_sub  = (op == OP_SUB) || (op == OP_SUBI);
    is_rem  = (op == OP_REM);
    b_sel   = use_imm ? imm_ext : op_b;
  end

  alu_addsub #(.W(W)) u_addsub (
    .a(op_a), .b(b_sel), .do_sub(is_sub),
    .sum(as_sum), .ovf(as_ovf), .unf(as_unf)
  );

  alu_mult #(.W(W)) u_mult (
    .a(op_a), .b(op_b),
    .prod(mul_prod), .ovf(mul_ovf), .unf(mul_unf)
  );

  alu_divide #(.W(W)) u_divide (
    .a(op_a), .b(op_b), .want_rem(is_rem),
    .res(div_res), .ovf(div_ovf), .zero_div(div_zero)
  );

  always_comb begin
    result   = '0;
    nxt_of   = 1'b0;
    nxt_uf   = 1'b0;
    flag_act = FLG_KEEP;
    unique case (op)
      OP_ADD, OP_ADDI, OP_SUB, OP_SUBI: begin
        result   = as_sum;
        nxt_of   = as_ovf;
        nxt_uf   = as_unf;
        flag_act = FLG_LOAD;
      end
      OP_MUL: begin
        result   = mul_prod;
        nxt_of   = mul_ovf;
        nxt_uf   = mul_unf;
        flag_act = FLG_LOAD;
      end
      OP_QUOT, OP_REM: begin
        result   = div_res;
        nxt_of   = div_ovf;
        nxt_uf   = 1'b0;
        flag_act = FLG_LOAD;
      end
      OP_AND, OP_ANDI: begin
        result   = op_a & b_sel;
        flag_act = FLG_CLEAR;
      end
      OP_OR, OP_ORI: begin
        result   = op_a | b_sel;
        flag_act = FLG_CLEAR;
      end
      OP_XOR, OP_XORI: begin
        result   = op_a ^ b_sel;
        flag_act = FLG_CLEAR;
      end
      OP_NOT: begin
        result   = ~op_a;
        flag_act = FLG_CLEAR;
      end
      default: begin
        result   = '0;
        flag_act = FLG_KEEP;
      end
    endcase
  end

  assign flag_commit = valid;
  assign halt        = valid && div_zero && ((op == OP_QUOT) || (op == OP_REM));

  alu_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .commit(flag_commit), .act(flag_act),
    .of_in(nxt_of), .uf_in(nxt_uf), .of_q(of_flag), .uf_q(uf_flag)
  );
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         valid,
  input logic [3:0]   opcode,
  input logic [W-1:0] op_b,
  input logic [W-1:0] result,
  input logic         halt,
  input logic         of_flag,
  input logic         uf_flag
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  logic is_div, is_logic, is_keep;
  always_comb begin
    is_div   = (opcode == OP_QUOT) || (opcode == OP_REM);
    is_logic = (opcode == OP_AND) || (opcode == OP_OR) || (opcode == OP_XOR) ||
               (opcode == OP_NOT) || (opcode == OP_ANDI) || (opcode == OP_ORI) ||
               (opcode == OP_XORI);
    is_keep  = (opcode == OP_NOP) || (opcode == OP_RET);
  end

  p_halt_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_div && op_b == '0) |-> (halt && result == MAXV));

  p_zero_div_of_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_div && op_b == '0) |=> of_flag);

  p_div_no_uf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_div) |=> !uf_flag);

  p_logic_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_logic) |=> (!of_flag && !uf_flag));

  p_keep_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_keep) |=> ($stable(of_flag) && $stable(uf_flag)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> ($stable(of_flag) && $stable(uf_flag)));

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(of_flag && uf_flag));

  p_no_halt_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !halt);
endmodule

bind int_alu_flags alu_flags_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid(valid), .opcode(opcode), .op_b(op_b),
  .result(result), .halt(halt), .of_flag(of_flag), .uf_flag(uf_flag)
);

// File: tb/sim_int_alu_flags.sv
`timescale 1ns/1ps
module sim_int_alu_flags;
  localparam int W = 32;
  localparam int IMM_W = 16;
  localparam longint LMAX = 64'sd2147483647;
  localparam longint LMIN = -64'sd2147483648;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [3:0] opcode = 4'd0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [IMM_W-1:0] imm = '0;
  logic [W-1:0] result;
  logic halt, of_flag, uf_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit m_of = 1'b0, m_uf = 1'b0;

  always #2 clk = ~clk;

  int_alu_flags #(.W(W), .IMM_W(IMM_W)) u0 (
    .clk(clk), .rst_n(rst_n), .valid(valid), .opcode(opcode), .op_a(op_a),
    .op_b(op_b), .imm(imm), .result(result), .halt(halt),
    .of_flag(of_flag), .uf_flag(uf_flag)
  );

  task automatic check(input string req, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd1, 4'd10: return "R2";
      4'd2, 4'd11: return "R3";
      4'd3:        return "R4";
      4'd4, 4'd5:  return "R5";
      4'd0, 4'd15: return "R8";
      default:     return "R7";
    endcase
  endfunction

  // reference model built from the requirement text with 64-bit arithmetic
  task automatic model(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [IMM_W-1:0] im, input bit vld,
                       output logic [W-1:0] r, output bit h);
    longint la, lb, li, t;
    bit touch, nof, nuf;
    la = longint'($signed(a));
    lb = longint'($signed(b));
    li = longint'($signed(im));
    touch = 1'b1; nof = 1'b0; nuf = 1'b0; h = 1'b0; r = '0; t = 0;
    case (op)
      4'd1, 4'd10, 4'd2, 4'd11: begin
        if (op == 4'd10 || op == 4'd11) lb = li;
        t = (op == 4'd2 || op == 4'd11) ? la - lb : la + lb;
        r = t[W-1:0]; nof = t > LMAX; nuf = t < LMIN;
      end
      4'd3: begin
        t = la * lb;
        r = t[W-1:0]; nof = t > LMAX; nuf = t < LMIN;
      end
      4'd4, 4'd5: begin
        if (lb == 0) begin
          r = 32'h7FFF_FFFF; nof = 1'b1; h = vld;
        end else if (la == LMIN && lb == -1) begin
          r = (op == 4'd4) ? 32'h8000_0000 : 32'h0; nof = 1'b1;
        end else begin
          t = (op == 4'd4) ? la / lb : la % lb;
          r = t[W-1:0];
        end
      end
      4'd6:  r = a & b;
      4'd7:  r = a | b;
      4'd8:  r = a ^ b;
      4'd9:  r = ~a;
      4'd12: r = a & W'(li);
      4'd13: r = a | W'(li);
      4'd14: r = a ^ W'(li);
      default: touch = 1'b0;
    endcase
    if (vld && touch) begin
      m_of = nof; m_uf = nuf;
    end
  endtask

  // drive at negedge, check result before the edge, flags after it
  task automatic run_op(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [IMM_W-1:0] im, input bit vld, input string tag);
    logic [W-1:0] er;
    bit eh;
    string rq;
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; imm = im; valid = vld;
    model(op, a, b, im, vld, er, eh);
    rq = (tag != "") ? tag : req_of(op);
    #1;
    check(rq, "result", result, er);
    check((op == 4'd4 || op == 4'd5) ? "R6" : rq, "halt", {31'd0, halt}, {31'd0, eh});
    @(posedge clk);
    #1;
    check(vld ? rq : "R9", "of_flag", {31'd0, of_flag}, {31'd0, m_of});
    check(vld ? rq : "R9", "uf_flag", {31'd0, uf_flag}, {31'd0, m_uf});
    check("R11", "flags exclusive", {31'd0, of_flag & uf_flag}, 32'd0);
  endtask

  function automatic logic [W-1:0] pick();
    case ($urandom % 6)
      0: return $urandom;
      1: return W'($urandom % 200) - 32'd100;
      2: return 32'h7FFF_FFFF - ($urandom % 16);
      3: return 32'h8000_0000 + ($urandom % 16);
      4: return W'($urandom % 65536) << ($urandom % 16);
      default: return ($urandom % 2) ? 32'hFFFF_FFFF : 32'h0;
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    #1;
    check("R10", "of after reset", {31'd0, of_flag}, 32'd0);
    check("R10", "uf after reset", {31'd0, uf_flag}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    // directed corners
    run_op(4'd1,  32'h7FFF_FFFF, 32'd1, '0, 1'b1, "R2");        // add above MAX
    run_op(4'd0,  32'd5, 32'd6, '0, 1'b1, "R8");                // no-op keeps OF
    run_op(4'd15, 32'd5, 32'd6, '0, 1'b1, "R8");                // return keeps OF
    run_op(4'd1,  32'h8000_0000, 32'hFFFF_FFFF, '0, 1'b1, "R2"); // add below MIN
    run_op(4'd1,  32'h8000_0000, 32'hFFFF_FFFF, '0, 1'b0, "R9"); // idle, hold
    run_op(4'd10, 32'h7FFF_FFF0, '0, 16'h0010, 1'b1, "R1");     // addi +16 overflows
    run_op(4'd10, 32'd5, '0, 16'hFFFE, 1'b1, "R1");             // addi -2 sign-extended
    run_op(4'd2,  32'h8000_0000, 32'd1, '0, 1'b1, "R3");        // sub below MIN
    run_op(4'd11, 32'h7FFF_FFFF, '0, 16'hFFFF, 1'b1, "R3");     // subi -1 above MAX
    run_op(4'd6,  32'hF0F0_1234, 32'h0FF0_FFFF, '0, 1'b1, "R7"); // and clears
    run_op(4'd3,  32'h8000_0000, 32'hFFFF_FFFF, '0, 1'b1, "R4"); // MIN * -1
    run_op(4'd3,  32'h0001_0000, 32'hFFFF_0000, '0, 1'b1, "R4"); // product below MIN
    run_op(4'd4,  32'd7, 32'd0, '0, 1'b1, "R6");                // divide by zero
    run_op(4'd5,  32'd7, 32'd0, '0, 1'b0, "R9");                // idle: no halt, hold
    run_op(4'd4,  32'h8000_0000, 32'hFFFF_FFFF, '0, 1'b1, "R5"); // MIN / -1
    run_op(4'd5,  32'h8000_0000, 32'hFFFF_FFFF, '0, 1'b1, "R5");
    run_op(4'd4,  32'hFFFF_FFF9, 32'd2, '0, 1'b1, "R5");        // -7/2 = -3
    run_op(4'd5,  32'hFFFF_FFF9, 32'd2, '0, 1'b1, "R5");        // -7%2 = -1
    run_op(4'd9,  32'h1234_5678, '0, '0, 1'b1, "R7");
    run_op(4'd14, 32'h0000_FFFF, '0, 16'h8001, 1'b1, "R7");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op;
      logic [W-1:0] a, b;
      op = 4'($urandom % 16);
      a  = pick();
      b  = pick();
      if (($urandom % 20) == 0) b = '0;
      run_op(op, a, b, 16'($urandom), ($urandom % 8) != 0, "");
    end

    // reset in mid-run after setting a flag
    run_op(4'd1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, '0, 1'b1, "R2");
    @(negedge clk) rst_n = 1'b0;
    #1;
    m_of = 1'b0; m_uf = 1'b0;
    check("R10", "of after mid reset", {31'd0, of_flag}, 32'd0);
    check("R10", "uf after mid reset", {31'd0, uf_flag}, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule